// File: doc/BRIEF.md
# Synchronized Debug Serial Port

This block is the target side of a bit-serial link between an external debugger and an on-chip debug module. Everything runs on the system clock. The serial clock and serial data input arrive asynchronously, and each passes through a synchronizer chain before any logic uses it. A serial-clock level is only believed once two consecutive system-clock samples agree on it. A one-cycle spike on the line is therefore dropped. Every accepted low-to-high transition of the serial clock does two things: it captures one input bit and it moves the registered output to its next bit.

Packets are 17 bits long and travel most significant bit first. Bit 16 is a flag or control bit, and bits 15:0 carry the payload. After the seventeenth accepted rise, the received word is presented with a single-cycle strobe. The debug logic answers by loading a 17-bit response, which is shifted out during the next packet. If no response has been loaded when a packet starts, the port sends a "not ready" word instead: flag bit set and payload zero.

Top module: `dbg_serial_port`

## Requirements
- R1: A serial-clock level is accepted only after two consecutive system-clock samples of the synchronized line agree. A high pulse lasting one system-clock cycle produces no rise: it captures no bit and leaves `ser_dout_o` unchanged.
- R2: On each accepted rise, the synchronized `ser_din_i` is captured. Bits fill the received word from bit 16 (first bit) down to bit 0 (seventeenth bit).
- R3: After the seventeenth accepted rise of a packet, `rx_valid_o` is high for exactly one cycle. In that cycle `rx_data_o` holds the 17-bit word. The bit counter then returns to the start of a packet.
- R4: `ser_dout_o` is a flip-flop output. It changes only in the cycle that follows an accepted rise, and never on the raw external edge.
- R5: A `tx_load_i` pulse stores `tx_data_i` as the pending response. At accepted rise n (n = 0 for the first rise) of the next packet, `ser_dout_o` takes bit 16−n of that response.
- R6: If no response is pending when a packet starts, the packet transmits 0x10000 (bit 16 = 1, bits 15:0 = 0). A pending response is used for one packet only.
- R7: A `tx_load_i` pulse that arrives after the first rise of a packet has no effect on that packet. It becomes the response for the following packet.
- R8: A synchronous reset clears the synchronizers, the accepted level, the bit counter, the shift registers and the pending response. It drives `ser_dout_o` and `rx_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock from the debugger, idle low |
| ser_din_i | input | 1 | Asynchronous serial data from the debugger |
| ser_dout_o | output | 1 | Registered serial data to the debugger |
| tx_load_i | input | 1 | One-cycle strobe that stores a response word |
| tx_data_i | input | 17 | Response word, bit 16 = flag |
| rx_valid_o | output | 1 | One-cycle strobe: a received packet is ready |
| rx_data_o | output | 17 | Last received packet, MSB first on the wire |

## Verification
The assertions assume the serial-clock line is low when reset is released. They also assume each serial-clock level is held long enough to be accepted, so the line runs no faster than one fifth of the system clock rate. They further assume the serial data is stable from well before an accepted rise until it has been sampled. The stimulus holds each serial-clock phase for six system-clock cycles and changes data only while the serial clock is low. A deliberate single-cycle spike is the only violation injected, and it is used to exercise the filter.

// File: rtl/dbgsp_pkg.sv
package dbgsp_pkg;
    localparam int PKT_W = 17;
    localparam int PAY_W = PKT_W - 1;
    localparam int CNT_W = $clog2(PKT_W);

    typedef logic [PKT_W-1:0] pkt_t;

    typedef struct packed {
        logic             flag;
        logic [PAY_W-1:0] payload;
    } pkt_s;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    function automatic pkt_t not_ready_word();
        pkt_s w;
        w.flag    = 1'b1;
        w.payload = '0;
        return pkt_t'(w);
    endfunction
endpackage

// File: rtl/dbgsp_sync.sv
module dbgsp_sync
    import dbgsp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_a,
    input  logic din_a,
    output logic rise_o,
    output logic din_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_pipe;
    logic [TOP:0] din_pipe;
    logic         sclk_prev;
    lvl_e         lvl_q;
    logic         agree;
    logic         lvl_hi;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_pipe <= '0;
                    din_pipe  <= '0;
                end else begin
                    sclk_pipe <= sclk_a;
                    din_pipe  <= din_a;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_pipe <= '0;
                    din_pipe  <= '0;
                end else begin
                    sclk_pipe <= {sclk_pipe[TOP-1:0], sclk_a};
                    din_pipe  <= {din_pipe[TOP-1:0], din_a};
                end
            end
        end
    endgenerate

    assign agree  = (sclk_pipe[TOP] == sclk_prev);
    assign lvl_hi = (lvl_q == LVL_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            lvl_q     <= LVL_LOW;
        end else begin
            sclk_prev <= sclk_pipe[TOP];
            if (agree) lvl_q <= lvl_e'(sclk_pipe[TOP]);
        end
    end

    assign rise_o = agree && sclk_pipe[TOP] && !lvl_hi;
    assign din_o  = din_pipe[TOP];

    // R1: the accepted level turns high only after two agreeing samples
    assert_two_sample_rise_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl_hi) |-> ($past(sclk_pipe[TOP]) && $past(sclk_pipe[TOP], 2)));

    assert_two_sample_fall_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(lvl_hi) |-> (!$past(sclk_pipe[TOP]) && !$past(sclk_pipe[TOP], 2)));
endmodule

// File: rtl/dbgsp_shift.sv
module dbgsp_shift
    import dbgsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    input  logic din_i,
    input  logic tx_load_i,
    input  pkt_t tx_data_i,
    output logic dout_o,
    output logic rx_valid_o,
    output pkt_t rx_data_o
);
    localparam int LAST = PKT_W - 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST);

    logic [CNT_W-1:0] cnt_q;
    pkt_t             rx_sr;
    pkt_t             tx_sr;
    pkt_t             resp_q;
    logic             resp_full;
    logic             dout_q;
    logic             rx_valid_q;
    pkt_t             rx_data_q;
    pkt_t             start_word;
    logic             at_start;

    assign at_start   = (cnt_q == '0);
    assign start_word = resp_full ? resp_q : not_ready_word();

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            resp_q     <= '0;
            resp_full  <= 1'b0;
            dout_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= 1'b0;
            if (rise_i) begin
                rx_sr <= {rx_sr[PKT_W-2:0], din_i};
                if (at_start) begin
                    dout_q    <= start_word[LAST];
                    tx_sr     <= {start_word[PKT_W-2:0], 1'b0};
                    resp_full <= 1'b0;
                end else begin
                    dout_q <= tx_sr[LAST];
                    tx_sr  <= {tx_sr[PKT_W-2:0], 1'b0};
                end
                if (cnt_q == CNT_LAST) begin
                    cnt_q      <= '0;
                    rx_valid_q <= 1'b1;
                    rx_data_q  <= {rx_sr[PKT_W-2:0], din_i};
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            // a load in the same cycle as a first rise wins and waits for the next packet
            if (tx_load_i) begin
                resp_q    <= tx_data_i;
                resp_full <= 1'b1;
            end
        end
    end

    assign dout_o     = dout_q;
    assign rx_valid_o = rx_valid_q;
    assign rx_data_o  = rx_data_q;

    // R4: the output bit only moves right after an accepted rise
    assert_dout_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_q) |-> $past(rise_i));

    // R3: strobe lasts a single cycle
    assert_rx_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid_q |=> !rx_valid_q);

    // R3: strobe follows the last rise of a packet
    assert_rx_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid_q |-> ($past(rise_i) && ($past(cnt_q) == CNT_LAST)));

    // R3: counter stays within one packet
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);

    // R6: a pending response is consumed at the start of a packet
    assert_resp_used_R6: assert property (@(posedge clk) disable iff (rst)
        (rise_i && at_start && !tx_load_i) |=> !resp_full);
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbgsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_din_i,
    output logic             ser_dout_o,
    input  logic             tx_load_i,
    input  logic [PKT_W-1:0] tx_data_i,
    output logic             rx_valid_o,
    output logic [PKT_W-1:0] rx_data_o
);
    logic rise;
    logic din_s;

    dbgsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_a (ser_clk_i),
        .din_a  (ser_din_i),
        .rise_o (rise),
        .din_o  (din_s)
    );

    dbgsp_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .din_i      (din_s),
        .tx_load_i  (tx_load_i),
        .tx_data_i  (tx_data_i),
        .dout_o     (ser_dout_o),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o)
    );
endmodule

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb;
    import dbgsp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WDOG       = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic tx_load = 1'b0;
    pkt_t tx_data = '0;
    logic rx_valid;
    pkt_t rx_data;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;
    pkt_t exp_q[$];
    logic prev_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_serial_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (ser_clk),
        .ser_din_i  (ser_din),
        .ser_dout_o (ser_dout),
        .tx_load_i  (tx_load),
        .tx_data_i  (tx_data),
        .rx_valid_o (rx_valid),
        .rx_data_o  (rx_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected received words; R2 / R3
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_v) check(!rx_valid, "R3 strobe width", 32'(rx_valid), 32'd0);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected strobe", 32'(rx_data), 32'd0);
                end else begin
                    pkt_t e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R2 received word", 32'(rx_data), 32'(e));
                end
            end
        end
        prev_v <= rx_valid;
    end

    task automatic serial_bits(input pkt_t w, input int nbits, output pkt_t got);
        got = '0;
        for (int i = PKT_W - 1; i >= PKT_W - nbits; i--) begin
            ser_din = w[i];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            got[i] = ser_dout;
            ser_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send(input pkt_t w, input pkt_t exp_tx, input string req);
        pkt_t got;
        exp_q.push_back(w);
        serial_bits(w, PKT_W, got);
        check(got == exp_tx, req, 32'(got), 32'(exp_tx));
    endtask

    task automatic load(input pkt_t w);
        @(negedge clk);
        tx_data = w;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        pkt_t dummy;
        logic held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(ser_dout == 1'b0, "R8 dout after reset", 32'(ser_dout), 32'd0);
        check(rx_valid == 1'b0, "R8 strobe after reset", 32'(rx_valid), 32'd0);

        // R6 no response loaded -> not ready
        send(17'h1A5C3, 17'h10000, "R6 not-ready word");
        // R5 loaded response goes out MSB first
        load(17'h0B00F);
        send(17'h00001, 17'h0B00F, "R5 response word");
        // R6 response used once
        send(17'h10000, 17'h10000, "R6 response consumed");
        load(17'h1FFFF);
        send(17'h0FFFF, 17'h1FFFF, "R5 all-ones response");
        load(17'h05555);
        send(17'h0AAAA, 17'h05555, "R5 alternating response");

        // R7 load after packet start waits for next packet
        fork
            send(17'h12345, 17'h10000, "R7 late load not used");
            begin
                repeat (40) @(negedge clk);
                load(17'h0C3A5);
            end
        join
        send(17'h03C3C, 17'h0C3A5, "R7 late load next packet");

        // R1 single-cycle spike ignored
        held = ser_dout;
        @(negedge clk);
        ser_clk = 1'b1;
        @(negedge clk);
        ser_clk = 1'b0;
        repeat (10) @(negedge clk);
        check(ser_dout == held, "R1 spike leaves dout", 32'(ser_dout), 32'(held));
        check(rx_valid == 1'b0, "R1 spike no strobe", 32'(rx_valid), 32'd0);
        load(17'h1E001);
        send(17'h1F0F0, 17'h1E001, "R1 alignment after spike");

        // R8 reset in mid packet clears counter and pending response
        load(17'h07777);
        serial_bits(17'h1FFFF, 8, dummy);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ser_dout == 1'b0, "R8 dout after mid reset", 32'(ser_dout), 32'd0);
        send(17'h00F0F, 17'h10000, "R8 pending cleared, aligned");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R3 all packets strobed", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule